// File: doc/BRIEF.md
# Line-to-Message Interrupt Redirection Controller

This block turns a group of wire-based interrupt inputs into interrupt messages, each one a memory-write request that carries a destination address and a data word. Every input line has its own two-word redirection entry. The low word holds the line's mask, input polarity, trigger mode and the message code that is sent when the line fires. The high word holds the destination fields. These fields are placed into a fixed address base to form the message address.

Software reaches the block through three byte offsets. An index register selects one internal register. A data window reads or writes the register that the index selects. An end-of-interrupt port takes a message code. Edge-triggered lines latch a pending bit on each active transition. Level-triggered lines send one message and then stay in service until software writes the matching code to the end-of-interrupt port. When more than one line is ready to send, the lowest-numbered line goes first. A message is held on a valid/ready handshake until the receiver takes it.

Top module: `irq_msg_ctrl`

## Requirements
- R1: After reset, every table entry reads low word 0x00010000 (masked, edge, active-high, code 0) and high word 0, and `msg_valid` is low.
- R2: Internal index 0x01 reads {8'h0, NUM_LINES-1, 8'h0, VERSION}: the version sits in bits 7:0 and the highest entry number sits in bits 23:16.
- R3: Byte offset 0x00 reads back the index. Through the window at offset 0x10, the low word of entry n sits at index 0x10+2n and its high word at 0x11+2n. Each one reads back exactly the value last written to it.
- R4: A line whose low-word bit 16 is set sends no message, whatever its input does.
- R5: With low-word bit 15 clear (edge mode), each active transition sends exactly one message. A line held at its active level sends no further messages.
- R6: With low-word bit 13 set, the input is active-low: a falling input is the active transition and a rising input sends nothing.
- R7: With low-word bit 15 set (level mode), an active unmasked line sends one message and then sends nothing more while it stays in service.
- R8: A write to offset 0x40 whose bits 7:0 equal a level line's code ends that line's service. If the line is still active, a new message follows. A write with a different code has no effect, and a matching write to a line that is no longer active sends nothing.
- R9: A message carries data {24'h0, low[7:0]} and address {ADDR_BASE[11:0], high[31:16], 4'h0}.
- R10: When several lines are ready to send, messages go out in ascending line order.
- R11: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold steady.
- R12: Clearing the mask of a line that is pending (edge) or active (level) sends its message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Byte offset: 0x00 index, 0x10 window, 0x40 end-of-interrupt |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_lines | input | NUM_LINES | Interrupt input wires |
| msg_valid | output | 1 | Message request valid |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_addr | output | 32 | Message destination address |
| msg_data | output | 32 | Message data |

## Verification
The assertions assume that `msg_ready` is meaningful only while `msg_valid` is high. They also assume that the interrupt inputs are synchronous to `clk`. The stimulus drives every input at the falling edge and raises ready only after it has looked at a held message. Lines change trigger mode or polarity only while they are masked and in level mode, so a reconfiguration never creates an edge by itself. Random table values keep the mask bit set and the polarity bit clear. Random priority rounds fire a random group of lines in one cycle and expect their messages in ascending order.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  localparam logic [6:0] OFS_INDEX  = 7'h00;
  localparam logic [6:0] OFS_WINDOW = 7'h10;
  localparam logic [6:0] OFS_EOI    = 7'h40;

  localparam logic [7:0] IDX_VERSION    = 8'h01;
  localparam logic [7:0] IDX_TABLE_BASE = 8'h10;

  localparam int BIT_MASK    = 16;
  localparam int BIT_LEVEL   = 15;
  localparam int BIT_ACT_LOW = 13;
  localparam int CODE_W      = 8;

  typedef struct packed {
    logic              masked;
    logic              level;
    logic              act_low;
    logic [CODE_W-1:0] code;
  } line_cfg_t;

  // pull the per-line control fields out of a low word
  function automatic line_cfg_t unpack_lo(input logic [31:0] lo);
    line_cfg_t c;
    c.masked  = lo[BIT_MASK];
    c.level   = lo[BIT_LEVEL];
    c.act_low = lo[BIT_ACT_LOW];
    c.code    = lo[CODE_W-1:0];
    return c;
  endfunction

  // destination fields of the high word slot into the fixed base
  function automatic logic [31:0] form_addr(input logic [11:0] base, input logic [31:0] hi);
    return {base, hi[31:16], 4'h0};
  endfunction

  function automatic logic [31:0] form_data(input logic [CODE_W-1:0] code);
    return {{(32-CODE_W){1'b0}}, code};
  endfunction

  function automatic logic [31:0] form_version(input logic [7:0] ver, input logic [7:0] top_entry);
    return {8'h00, top_entry, 8'h00, ver};
  endfunction
endpackage

// File: rtl/irqm_table.sv
module irqm_table
  import irqm_pkg::*;
#(
  parameter int         N   = 8,
  parameter logic [7:0] VER = 8'h21
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [6:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic [N-1:0][31:0]  lo_words,
  output logic [N-1:0][31:0]  hi_words,
  output logic                eoi_evt,
  output logic [CODE_W-1:0]   eoi_code
);
  localparam int         EW      = $clog2(N);
  localparam logic [8:0] TAB_END = 9'(16 + 2 * N);
  localparam logic [31:0] LO_RST = 32'd1 << BIT_MASK;

  logic [7:0]          idx_q;
  logic [N-1:0][31:0]  lo_q, hi_q;
  logic [7:0]          idx_off;
  logic                in_tab;
  logic [EW-1:0]       ent;
  logic                wr_win;
  logic [31:0]         win_rd;

  assign idx_off = idx_q - IDX_TABLE_BASE;
  assign in_tab  = (idx_q >= IDX_TABLE_BASE) && ({1'b0, idx_q} < TAB_END);
  assign ent     = EW'(idx_off >> 1);
  assign wr_win  = reg_we && (reg_addr == OFS_WINDOW) && in_tab;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      for (int i = 0; i < N; i++) begin
        lo_q[i] <= LO_RST;
        hi_q[i] <= '0;
      end
    end else begin
      if (reg_we && (reg_addr == OFS_INDEX)) idx_q <= reg_wdata[7:0];
      if (wr_win) begin
        if (idx_q[0]) hi_q[ent] <= reg_wdata;
        else          lo_q[ent] <= reg_wdata;
      end
    end
  end

  always_comb begin
    win_rd = '0;
    if (idx_q == IDX_VERSION) win_rd = form_version(VER, 8'(N - 1));
    else if (in_tab)          win_rd = idx_q[0] ? hi_q[ent] : lo_q[ent];
    reg_rdata = '0;
    case (reg_addr)
      OFS_INDEX:  reg_rdata = {24'h0, idx_q};
      OFS_WINDOW: reg_rdata = win_rd;
      default:    reg_rdata = '0;
    endcase
  end

  assign lo_words = lo_q;
  assign hi_words = hi_q;
  assign eoi_evt  = reg_we && (reg_addr == OFS_EOI);
  assign eoi_code = reg_wdata[CODE_W-1:0];
endmodule

// File: rtl/irqm_src.sv
module irqm_src
  import irqm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_in,
  input  line_cfg_t         cfg,
  input  logic              eoi_evt,
  input  logic [CODE_W-1:0] eoi_code,
  input  logic              grant,
  output logic              req,
  output logic              in_svc
);
  logic act, act_q, pend_q, svc_q, rise;

  assign act  = line_in ^ cfg.act_low;
  assign rise = act && !act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      svc_q  <= 1'b0;
    end else begin
      act_q  <= act;
      pend_q <= cfg.level ? 1'b0 : ((pend_q && !grant) || rise);
      if (!cfg.level)                             svc_q <= 1'b0;
      else if (grant)                             svc_q <= 1'b1;
      else if (eoi_evt && (eoi_code == cfg.code)) svc_q <= 1'b0;
    end
  end

  assign req    = !cfg.masked && (cfg.level ? (act && !svc_q) : pend_q);
  assign in_svc = svc_q;
endmodule

// File: rtl/irqm_arb.sv
module irqm_arb #(
  parameter int N = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N-1:0]           req,
  input  logic [31:0]            cand_addr,
  input  logic [31:0]            cand_data,
  input  logic                   msg_ready,
  output logic [$clog2(N)-1:0]   pick,
  output logic                   load_evt,
  output logic [N-1:0]           grant_vec,
  output logic                   msg_valid,
  output logic [31:0]            msg_addr,
  output logic [31:0]            msg_data
);
  localparam int EW = $clog2(N);

  logic          valid_q;
  logic [EW-1:0] line_q;

  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--) if (req[i]) pick = EW'(i);
  end

  assign load_evt = !valid_q && (|req);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      line_q   <= '0;
      msg_addr <= '0;
      msg_data <= '0;
    end else if (load_evt) begin
      valid_q  <= 1'b1;
      line_q   <= pick;
      msg_addr <= cand_addr;
      msg_data <= cand_data;
    end else if (valid_q && msg_ready) begin
      valid_q  <= 1'b0;
    end
  end

  always_comb begin
    grant_vec = '0;
    if (valid_q && msg_ready) grant_vec[line_q] = 1'b1;
  end

  assign msg_valid = valid_q;
endmodule

// File: rtl/irq_msg_ctrl.sv
module irq_msg_ctrl
  import irqm_pkg::*;
#(
  parameter int          NUM_LINES = 8,
  parameter logic [7:0]  VERSION   = 8'h21,
  parameter logic [11:0] ADDR_BASE = 12'hFEE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [6:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [NUM_LINES-1:0] irq_lines,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [31:0]          msg_addr,
  output logic [31:0]          msg_data
);
  localparam int EW = $clog2(NUM_LINES);

  logic [NUM_LINES-1:0][31:0] lo_words, hi_words;
  logic                       eoi_evt;
  logic [CODE_W-1:0]          eoi_code;
  line_cfg_t                  cfg_vec [NUM_LINES];
  logic [NUM_LINES-1:0]       req_vec, svc_vec, mask_vec, grant_vec;
  logic [EW-1:0]              load_line;
  logic                       load_evt;
  logic [31:0]                cand_addr, cand_data;

  irqm_table #(.N(NUM_LINES), .VER(VERSION)) u_table (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lo_words(lo_words),
    .hi_words(hi_words), .eoi_evt(eoi_evt), .eoi_code(eoi_code)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign cfg_vec[g]  = unpack_lo(lo_words[g]);
    assign mask_vec[g] = cfg_vec[g].masked;
    irqm_src u_src (
      .clk(clk), .rst_n(rst_n), .line_in(irq_lines[g]), .cfg(cfg_vec[g]),
      .eoi_evt(eoi_evt), .eoi_code(eoi_code), .grant(grant_vec[g]),
      .req(req_vec[g]), .in_svc(svc_vec[g])
    );
  end

  assign cand_addr = form_addr(ADDR_BASE, hi_words[load_line]);
  assign cand_data = form_data(cfg_vec[load_line].code);

  irqm_arb #(.N(NUM_LINES)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req_vec), .cand_addr(cand_addr),
    .cand_data(cand_data), .msg_ready(msg_ready), .pick(load_line),
    .load_evt(load_evt), .grant_vec(grant_vec), .msg_valid(msg_valid),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );
endmodule

// File: rtl/irqm_chk.sv
module irqm_chk #(
  parameter int N = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 msg_valid,
  input logic                 msg_ready,
  input logic [31:0]          msg_addr,
  input logic [31:0]          msg_data,
  input logic                 load_evt,
  input logic [$clog2(N)-1:0] load_line,
  input logic [N-1:0]         req_vec,
  input logic [N-1:0]         mask_vec,
  input logic [N-1:0]         svc_vec,
  input logic [N-1:0]         grant_vec
);
  logic [N-1:0] below;
  assign below = (N'(1) << load_line) - N'(1);

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  // R10
  lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> (req_vec[load_line] && ((req_vec & below) == '0)));

  // R4
  masked_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> !mask_vec[load_line]);

  // R7
  in_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> !svc_vec[load_line]);

  // R5
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vec != '0) |-> ($onehot0(grant_vec) && msg_valid && msg_ready));

  // R11
  drop_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready) |=> !msg_valid);
endmodule

bind irq_msg_ctrl irqm_chk #(.N(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data), .load_evt(load_evt),
  .load_line(load_line), .req_vec(req_vec), .mask_vec(mask_vec),
  .svc_vec(svc_vec), .grant_vec(grant_vec)
);

// File: tb/irq_msg_ctrl_test.sv
`timescale 1ns/1ps
module irq_msg_ctrl_test;
  localparam int          NL   = 8;
  localparam logic [7:0]  VER  = 8'h21;
  localparam logic [11:0] BASE = 12'hFEE;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_we;
  logic [6:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [NL-1:0] irq_lines;
  logic msg_valid, msg_ready;
  logic [31:0] msg_addr, msg_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [31:0] rd, val, hi_tab [NL];
  logic [7:0] subset;
  int ent;
  bit hsel;

  always #2.5 clk = ~clk;

  irq_msg_ctrl #(.NUM_LINES(NL), .VERSION(VER), .ADDR_BASE(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_lines(irq_lines),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
    .msg_data(msg_data)
  );

  function automatic logic [31:0] mk_lo(bit m, bit lvl, bit alow, logic [7:0] code);
    return (32'(m) << 16) | (32'(lvl) << 15) | (32'(alow) << 13) | 32'(code);
  endfunction
  function automatic logic [31:0] exp_addr(logic [31:0] hi);
    return (32'(BASE) << 20) | ((hi >> 16) << 4);
  endfunction
  function automatic logic [31:0] exp_data(logic [31:0] lo);
    return lo & 32'h0000_00FF;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [6:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask
  task automatic reg_read(input logic [6:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask
  task automatic win_write(input logic [7:0] idx, input logic [31:0] d);
    reg_write(7'h00, 32'(idx));
    reg_write(7'h10, d);
  endtask
  task automatic win_read(input logic [7:0] idx, output logic [31:0] d);
    reg_write(7'h00, 32'(idx));
    reg_read(7'h10, d);
  endtask
  task automatic eoi(input logic [7:0] code);
    reg_write(7'h40, 32'(code));
  endtask

  task automatic expect_msg(input logic [31:0] ea, input logic [31:0] ed, input string tag);
    int w = 0;
    while (!msg_valid && w < 30) begin @(negedge clk); w++; end
    check(msg_valid == 1'b1, {tag, " message valid"}, 32'(msg_valid), 32'd1);
    if (msg_valid) begin
      check(msg_addr == ea, {tag, " R9 address"}, msg_addr, ea);
      check(msg_data == ed, {tag, " R9 data"}, msg_data, ed);
      repeat (3) @(negedge clk);
      check(msg_valid && msg_addr == ea && msg_data == ed, {tag, " R11 held"}, msg_data, ed);
      msg_ready = 1'b1;
      @(negedge clk);
      msg_ready = 1'b0;
    end
  endtask

  task automatic expect_none(input int cyc, input string tag);
    bit seen = 1'b0;
    repeat (cyc) begin @(negedge clk); if (msg_valid) seen = 1'b1; end
    check(!seen, {tag, " no message"}, 32'(seen), 32'd0);
  endtask

  initial begin
    #(5 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    irq_lines = '0; msg_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(msg_valid == 1'b0, "R1 valid after reset", 32'(msg_valid), 32'd0);
    for (int i = 0; i < NL; i++) begin
      win_read(8'(16 + 2 * i), rd);
      check(rd == 32'h0001_0000, "R1 low word reset", rd, 32'h0001_0000);
      win_read(8'(17 + 2 * i), rd);
      check(rd == 32'h0, "R1 high word reset", rd, 32'h0);
    end

    // R2 version register
    win_read(8'h01, rd);
    check(rd == ((32'(NL - 1) << 16) | 32'(VER)), "R2 version", rd, (32'(NL - 1) << 16) | 32'(VER));

    // R3 index read-back and random window read-back
    reg_write(7'h00, 32'h0000_0013);
    reg_read(7'h00, rd);
    check(rd == 32'h13, "R3 index readback", rd, 32'h13);
    for (int k = 0; k < 12; k++) begin
      ent  = $urandom_range(NL - 1, 0);
      hsel = 1'($urandom_range(1, 0));
      val  = ($urandom() | 32'h0001_0000) & ~32'h0000_2000;
      win_write(8'(16 + 2 * ent + int'(hsel)), val);
      win_read(8'(16 + 2 * ent + int'(hsel)), rd);
      check(rd == val, "R3 window readback", rd, val);
    end
    for (int i = 0; i < NL; i++) begin
      win_write(8'(16 + 2 * i), 32'h0001_0000);
      win_write(8'(17 + 2 * i), 32'h0);
    end
    expect_none(6, "R4 all masked");

    // R5 + R9 edge line 2
    hi_tab[2] = $urandom() & 32'hFFFF_0000;
    win_write(8'h15, hi_tab[2]);
    val = mk_lo(1'b0, 1'b0, 1'b0, 8'h5A);
    win_write(8'h14, val);
    irq_lines[2] = 1'b1;
    expect_msg(exp_addr(hi_tab[2]), exp_data(val), "R5 edge first");
    expect_none(10, "R5 held level no repeat");
    irq_lines[2] = 1'b0;
    expect_none(4, "R5 falling edge");
    irq_lines[2] = 1'b1;
    @(negedge clk);
    irq_lines[2] = 1'b0;
    expect_msg(exp_addr(hi_tab[2]), exp_data(val), "R5 edge pulse");

    // R6 active-low edge line 5
    hi_tab[5] = 32'hA0FF_0000;
    win_write(8'h1B, hi_tab[5]);
    win_write(8'h1A, mk_lo(1'b1, 1'b1, 1'b1, 8'h00));
    irq_lines[5] = 1'b1;
    @(negedge clk);
    val = mk_lo(1'b0, 1'b0, 1'b1, 8'hC3);
    win_write(8'h1A, val);
    expect_none(4, "R6 idle high quiet");
    irq_lines[5] = 1'b0;
    expect_msg(exp_addr(hi_tab[5]), exp_data(val), "R6 falling fires");
    irq_lines[5] = 1'b1;
    expect_none(8, "R6 rising ignored");

    // R7 + R8 level line 4
    hi_tab[4] = $urandom() & 32'hFFFF_0000;
    win_write(8'h19, hi_tab[4]);
    val = mk_lo(1'b0, 1'b1, 1'b0, 8'h44);
    win_write(8'h18, val);
    irq_lines[4] = 1'b1;
    expect_msg(exp_addr(hi_tab[4]), exp_data(val), "R7 level first");
    expect_none(10, "R7 in service");
    eoi(8'h45);
    expect_none(8, "R8 wrong code");
    eoi(8'h44);
    expect_msg(exp_addr(hi_tab[4]), exp_data(val), "R8 reissue while asserted");
    irq_lines[4] = 1'b0;
    @(negedge clk);
    eoi(8'h44);
    expect_none(8, "R8 eoi after deassert");
    irq_lines[4] = 1'b1;
    expect_msg(exp_addr(hi_tab[4]), exp_data(val), "R8 rearmed");
    irq_lines[4] = 1'b0;
    @(negedge clk);
    eoi(8'h44);

    // R4 + R12 masked level line 6
    hi_tab[6] = 32'h1234_0000;
    win_write(8'h1D, hi_tab[6]);
    val = mk_lo(1'b1, 1'b1, 1'b0, 8'h66);
    win_write(8'h1C, val);
    irq_lines[6] = 1'b1;
    expect_none(10, "R4 masked level");
    val = mk_lo(1'b0, 1'b1, 1'b0, 8'h66);
    win_write(8'h1C, val);
    expect_msg(exp_addr(hi_tab[6]), exp_data(val), "R12 unmask level");

    // R4 + R12 masked edge line 1
    hi_tab[1] = 32'hBEEF_0000;
    win_write(8'h13, hi_tab[1]);
    win_write(8'h12, mk_lo(1'b1, 1'b0, 1'b0, 8'h11));
    irq_lines[1] = 1'b1;
    @(negedge clk);
    irq_lines[1] = 1'b0;
    expect_none(10, "R4 masked edge");
    val = mk_lo(1'b0, 1'b0, 1'b0, 8'h11);
    win_write(8'h12, val);
    expect_msg(exp_addr(hi_tab[1]), exp_data(val), "R12 unmask pending edge");

    // R10 priority: quiet everything, then random groups of edges
    for (int i = 0; i < NL; i++) win_write(8'(16 + 2 * i), mk_lo(1'b1, 1'b1, 1'b0, 8'h00));
    irq_lines = '0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < NL; i++) begin
      hi_tab[i] = $urandom() & 32'hFFFF_0000;
      win_write(8'(17 + 2 * i), hi_tab[i]);
      win_write(8'(16 + 2 * i), mk_lo(1'b0, 1'b0, 1'b0, 8'(8'h40 + i)));
    end
    expect_none(4, "R10 quiet before rounds");
    for (int r = 0; r < 4; r++) begin
      subset = 8'($urandom()) | 8'h81;
      irq_lines = subset;
      @(negedge clk);
      irq_lines = '0;
      for (int i = 0; i < NL; i++)
        if (subset[i]) expect_msg(exp_addr(hi_tab[i]), 32'(8'h40 + i), "R10 ascending order");
      expect_none(4, "R10 round drained");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule